// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

This block watches one synchronous digital input and records when its level changes. On every change it stores the value of a shared free-running system counter, masked to a selectable low-order slice, and it stores the level the input had before the change. Because the stored value is absolute time and not time since the last edge, several units driven by the same counter give stamps that software can compare across inputs and subtract to get durations.

If the selected counter slice rolls over from all ones to zero while the input holds still, the unit raises its event flag but leaves the stored stamp and level untouched. Software can tell this timeout from a real capture by seeing that nothing changed, and it can count timeouts to extend the time base. A resolution field picks the slice width, and that width sets both the timeout period and how many result bytes carry meaning. A coarse mode steps the width in 8-bit units and a fine mode steps it in 4-bit units. The event flag stays set until a read acknowledge.

Top module: `edge_stamp_unit`

## Requirements
- R1: After reset, event_o, prior_o and stamp_o are all zero, and the internal copy of the input level is 0.
- R2: When pin_i differs from its level in the previous cycle, event_o is 1 in the next cycle and prior_o holds the level before the change.
- R3: On a level change, stamp_o takes sys_cnt_i from the cycle of the change, ANDed with the slice mask. It does not take an elapsed count. Without a change, stamp_o and prior_o hold their values.
- R4: If the masked slice of sys_cnt_i is all ones in one cycle and zero in the next, and pin_i does not change, event_o becomes 1 and stamp_o and prior_o stay unchanged.
- R5: A masked slice that becomes zero from any value other than all ones does not raise event_o.
- R6: The slice width is 8*(res_i+1) when fine_i=0 and 4*(res_i+1) when fine_i=1, capped at CNT_W. Stamp bits at or above the width read as zero.
- R7: nbytes_o equals the slice width divided by 8, rounded up.
- R8: If a level change and a slice wrap fall in the same cycle, the change is captured: stamp_o and prior_o update.
- R9: An ack_i pulse clears event_o in the next cycle. If a change or a wrap occurs in the cycle of the acknowledge, event_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Monitored input, already synchronous to clk_i |
| sys_cnt_i | input | CNT_W | Shared free-running system counter |
| res_i | input | RES_W | Resolution setting |
| fine_i | input | 1 | 1: width steps of 4 bits, 0: steps of 8 bits |
| ack_i | input | 1 | Read acknowledge, clears the event flag |
| event_o | output | 1 | Event flag, set by a capture or a timeout |
| prior_o | output | 1 | Input level before the last captured change |
| stamp_o | output | CNT_W | Captured counter slice |
| nbytes_o | output | $clog2(CNT_W/8+1) | Number of meaningful result bytes |

## Verification
The assertions check on every cycle that each input change sets the flag and loads the masked counter and the prior level one cycle later. They also check that the stored values hold whenever no change happens, that a rising flag always has a change or a wrap as its cause, that an acknowledge with no competing event clears the flag, and that the byte count follows the resolution setting. Only the bench scenarios show that a wrap is recognised exactly on the all-ones-to-zero step of the chosen slice and not on other steps to zero. They also show how each of the sixteen resolution settings masks the stamp, and how the two same-cycle collisions resolve: change with wrap, and event with acknowledge.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  // Slice width for a resolution setting, capped at the counter width.
  function automatic int unsigned slice_width(input bit fine, input int unsigned res,
                                               input int unsigned coarse_step,
                                               input int unsigned fine_step,
                                               input int unsigned cnt_w);
    int unsigned w;
    w = (fine ? fine_step : coarse_step) * (res + 1);
    return (w > cnt_w) ? cnt_w : w;
  endfunction
endpackage

// File: rtl/tsc_slice_cfg.sv
module tsc_slice_cfg #(
  parameter int CNT_W       = 32,
  parameter int RES_W       = 3,
  parameter int COARSE_STEP = 8,
  parameter int FINE_STEP   = 4,
  localparam int NB_W       = $clog2(CNT_W/8 + 1)
) (
  input  logic [RES_W-1:0] res_i,
  input  logic             fine_i,
  output logic [CNT_W-1:0] mask_o,
  output logic [NB_W-1:0]  nbytes_o
);
  localparam int WID_W = 16;

  logic [WID_W-1:0] wid_w;
  logic [WID_W-1:0] bytes_w;

  always_comb begin
    wid_w   = WID_W'(tsc_pkg::slice_width(fine_i, 32'(res_i), COARSE_STEP, FINE_STEP, CNT_W));
    bytes_w = (wid_w + WID_W'(7)) >> 3;
  end

  assign nbytes_o = bytes_w[NB_W-1:0];

  for (genvar g = 0; g < CNT_W; g++) begin : g_mask
    assign mask_o[g] = (wid_w > WID_W'(g));
  end
endmodule

// File: rtl/tsc_edge_det.sv
module tsc_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic edge_o,
  output logic prev_o
);
  logic pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pin_i;
  end

  assign edge_o = pin_i ^ pin_q;
  assign prev_o = pin_q;
endmodule

// File: rtl/tsc_wrap_det.sv
module tsc_wrap_det #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] mask_i,
  output logic             wrap_o
);
  logic [CNT_W-1:0] slice_w;
  logic             ones_q;

  assign slice_w = cnt_i & mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ones_q <= 1'b0;
    else         ones_q <= (slice_w == mask_i);
  end

  // all-ones last cycle, zero now
  assign wrap_o = ones_q && (slice_w == '0);
endmodule

// File: rtl/tsc_capture.sv
module tsc_capture #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  input  logic             wrap_i,
  input  logic             ack_i,
  input  logic             prev_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] mask_i,
  output logic             event_o,
  output logic             prior_o,
  output logic [CNT_W-1:0] stamp_o
);
  logic             evt_q;
  logic             prior_q;
  logic [CNT_W-1:0] stamp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q   <= 1'b0;
      prior_q <= 1'b0;
      stamp_q <= '0;
    end else begin
      if (edge_i) begin
        stamp_q <= cnt_i & mask_i;
        prior_q <= prev_i;
      end
      // new event wins over acknowledge
      if (edge_i || wrap_i) evt_q <= 1'b1;
      else if (ack_i)       evt_q <= 1'b0;
    end
  end

  assign event_o = evt_q;
  assign prior_o = prior_q;
  assign stamp_o = stamp_q;
endmodule

// File: rtl/edge_stamp_unit.sv
module edge_stamp_unit #(
  parameter int CNT_W       = 32,
  parameter int RES_W       = 3,
  parameter int COARSE_STEP = 8,
  parameter int FINE_STEP   = 4,
  localparam int NB_W       = $clog2(CNT_W/8 + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic [CNT_W-1:0] sys_cnt_i,
  input  logic [RES_W-1:0] res_i,
  input  logic             fine_i,
  input  logic             ack_i,
  output logic             event_o,
  output logic             prior_o,
  output logic [CNT_W-1:0] stamp_o,
  output logic [NB_W-1:0]  nbytes_o
);
  logic [CNT_W-1:0] mask_w;
  logic             edge_w;
  logic             prev_w;
  logic             wrap_w;

  tsc_slice_cfg #(
    .CNT_W(CNT_W), .RES_W(RES_W), .COARSE_STEP(COARSE_STEP), .FINE_STEP(FINE_STEP)
  ) u_cfg (
    .res_i(res_i), .fine_i(fine_i), .mask_o(mask_w), .nbytes_o(nbytes_o)
  );

  tsc_edge_det u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .edge_o(edge_w), .prev_o(prev_w)
  );

  tsc_wrap_det #(.CNT_W(CNT_W)) u_wrap (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(sys_cnt_i), .mask_i(mask_w), .wrap_o(wrap_w)
  );

  tsc_capture #(.CNT_W(CNT_W)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .edge_i(edge_w), .wrap_i(wrap_w), .ack_i(ack_i),
    .prev_i(prev_w), .cnt_i(sys_cnt_i), .mask_i(mask_w),
    .event_o(event_o), .prior_o(prior_o), .stamp_o(stamp_o)
  );
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
  parameter int CNT_W       = 32,
  parameter int RES_W       = 3,
  parameter int COARSE_STEP = 8,
  parameter int FINE_STEP   = 4,
  localparam int NB_W       = $clog2(CNT_W/8 + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pin_i,
  input logic [CNT_W-1:0] sys_cnt_i,
  input logic [RES_W-1:0] res_i,
  input logic             fine_i,
  input logic             ack_i,
  input logic             event_o,
  input logic             prior_o,
  input logic [CNT_W-1:0] stamp_o,
  input logic [NB_W-1:0]  nbytes_o,
  input logic             wrap_i
);
  logic             ck_pin;
  logic             ck_edge;
  int               ck_wid;
  logic [CNT_W:0]   ck_full;
  logic [CNT_W-1:0] ck_mask;
  logic [NB_W-1:0]  ck_nb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ck_pin <= 1'b0;
    else         ck_pin <= pin_i;
  end

  always_comb begin
    ck_edge = (pin_i != ck_pin);
    ck_wid  = (fine_i ? FINE_STEP : COARSE_STEP) * (int'(res_i) + 1);
    if (ck_wid > CNT_W) ck_wid = CNT_W;
    ck_full = ({{CNT_W{1'b0}}, 1'b1} << ck_wid) - 1'b1;
    ck_mask = ck_full[CNT_W-1:0];
    ck_nb   = NB_W'((ck_wid + 7) / 8);
  end

  AST_EDGE_SETS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ck_edge |=> event_o); // R2
  AST_PRIOR_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ck_edge |=> (prior_o != $past(pin_i))); // R2
  AST_STAMP_ABSOLUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ck_edge |=> (stamp_o == $past(sys_cnt_i & ck_mask))); // R3
  AST_HOLD_NO_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ck_edge |=> ($stable(stamp_o) && $stable(prior_o))); // R4
  AST_EVENT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o && !$past(event_o)) |-> $past(ck_edge || wrap_i)); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !ck_edge && !wrap_i) |=> !event_o); // R9
  AST_ACK_LOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && (ck_edge || wrap_i)) |=> event_o); // R9
  AST_NBYTES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nbytes_o == ck_nb); // R7
endmodule

bind edge_stamp_unit tsc_checker #(
  .CNT_W(CNT_W), .RES_W(RES_W), .COARSE_STEP(COARSE_STEP), .FINE_STEP(FINE_STEP)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .sys_cnt_i(sys_cnt_i), .res_i(res_i),
  .fine_i(fine_i), .ack_i(ack_i), .event_o(event_o), .prior_o(prior_o),
  .stamp_o(stamp_o), .nbytes_o(nbytes_o), .wrap_i(wrap_w)
);

// File: tb/edge_stamp_unit_bench.sv
module edge_stamp_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 32;
  localparam int RES_W = 3;
  localparam int NB_W  = $clog2(CNT_W/8 + 1);

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             pin = 1'b0;
  logic [CNT_W-1:0] cnt = 32'h1;
  logic [RES_W-1:0] res = '0;
  logic             fine = 1'b0;
  logic             ack = 1'b0;
  logic             event_o, prior_o;
  logic [CNT_W-1:0] stamp_o;
  logic [NB_W-1:0]  nbytes_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_stamp_unit u_edge_stamp_unit (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin), .sys_cnt_i(cnt), .res_i(res),
    .fine_i(fine), .ack_i(ack), .event_o(event_o), .prior_o(prior_o),
    .stamp_o(stamp_o), .nbytes_o(nbytes_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [CNT_W-1:0] exp_mask(input bit f, input int r);
    int w;
    w = (f ? 4 : 8) * (r + 1);
    if (w >= CNT_W) return '1;
    return (CNT_W'(1) << w) - CNT_W'(1);
  endfunction

  function automatic int exp_bytes(input bit f, input int r);
    int w;
    w = (f ? 4 : 8) * (r + 1);
    if (w > CNT_W) w = CNT_W;
    return (w + 7) / 8;
  endfunction

  task automatic do_ack();
    ack = 1'b1;
    tick();
    ack = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [CNT_W-1:0] val;
    logic             old_pin;
    logic [CNT_W-1:0] held;
    tick(); tick();
    rst_ni = 1'b1;
    tick();
    chk("R1 event", 64'(event_o), 64'd0);
    chk("R1 stamp", 64'(stamp_o), 64'd0);
    chk("R1 prior", 64'(prior_o), 64'd0);

    // sweep every resolution in both step modes
    for (int f = 0; f < 2; f++) begin
      for (int r = 0; r < 8; r++) begin
        val = (CNT_W'(32'h9E3779B1) * CNT_W'(f * 8 + r + 3)) | CNT_W'(1);
        old_pin = pin;
        res = RES_W'(r);
        fine = f[0];
        cnt = val;
        pin = ~pin;
        tick();
        chk("R2 event", 64'(event_o), 64'd1);
        chk("R2 prior", 64'(prior_o), 64'(old_pin));
        chk("R3 R6 stamp", 64'(stamp_o), 64'(val & exp_mask(f[0], r)));
        chk("R7 nbytes", 64'(nbytes_o), 64'(exp_bytes(f[0], r)));
        do_ack();
        chk("R9 cleared", 64'(event_o), 64'd0);
        chk("R3 hold", 64'(stamp_o), 64'(val & exp_mask(f[0], r)));
      end
    end

    // coarse 8-bit wrap
    res = '0; fine = 1'b0;
    cnt = 32'h0000_1101; pin = ~pin;
    tick(); do_ack();
    held = stamp_o;
    old_pin = prior_o;
    chk("R3 stamp 8b", 64'(held), 64'h01);
    cnt = 32'h0000_12FF; tick();
    chk("R5 no wrap yet", 64'(event_o), 64'd0);
    cnt = 32'h0000_1300; tick();
    chk("R4 wrap event", 64'(event_o), 64'd1);
    chk("R4 stamp kept", 64'(stamp_o), 64'(held));
    chk("R4 prior kept", 64'(prior_o), 64'(old_pin));
    do_ack();
    chk("R9 wrap cleared", 64'(event_o), 64'd0);
    cnt = 32'h0000_13FE; tick();
    cnt = 32'h0000_1400; tick();
    chk("R5 FE to 00", 64'(event_o), 64'd0);

    // fine 4-bit wrap
    fine = 1'b1; res = '0;
    cnt = 32'h0000_141F; tick();
    cnt = 32'h0000_1420; tick();
    chk("R4 R6 fine wrap", 64'(event_o), 64'd1);
    chk("R4 fine stamp kept", 64'(stamp_o), 64'(held));
    do_ack();

    // coarse 16-bit: low byte wrap is not a slice wrap
    fine = 1'b0; res = 3'd1;
    cnt = 32'h00AA_00FF; tick();
    cnt = 32'h00AA_0100; tick();
    chk("R5 R6 16b partial", 64'(event_o), 64'd0);
    cnt = 32'h0012_FFFF; tick();
    cnt = 32'h0013_0000; tick();
    chk("R4 16b wrap", 64'(event_o), 64'd1);
    do_ack();

    // change and wrap in one cycle
    res = '0;
    cnt = 32'h55AA_77FF; tick();
    old_pin = pin;
    cnt = 32'h55AA_7800; pin = ~pin; tick();
    chk("R8 event", 64'(event_o), 64'd1);
    chk("R8 stamp", 64'(stamp_o), 64'h00);
    chk("R8 prior", 64'(prior_o), 64'(old_pin));

    // acknowledge collides with a change
    cnt = 32'h55AA_7833; pin = ~pin; ack = 1'b1; tick(); ack = 1'b0;
    chk("R9 ack loses", 64'(event_o), 64'd1);
    chk("R9 stamp", 64'(stamp_o), 64'h33);
    do_ack();
    chk("R9 ack alone", 64'(event_o), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule